// File: doc/BRIEF.md
# Per-Column Flat Field Correction Pipeline

This block corrects a line-scan sensor's pixel stream column by column. Each column has an offset coefficient that removes fixed-pattern dark signal and a gain coefficient that evens out pixel sensitivity. Pixels arrive with a valid flag and a start-of-line marker. An internal column counter follows the stream and looks up both coefficients for the pixel in flight. Each output pixel is `(in - offset) * gain`, rounded to the nearest integer and saturated to the 12-bit range.

The coefficients live in two per-column memories. A single write port loads them at any time, with a select bit that picks the bank. A strobe for each bank clears it to neutral in one cycle: offset 0 and gain x1. A bypass control sends pixels through unchanged. Whichever path is taken, the output arrives exactly three clock cycles after the input, and the valid and start-of-line flags are delayed to match.

Top module: `ffc_pixel_pipe`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_sol` and `out_data` are all 0.
- R2: A pixel accepted at a clock edge appears on the outputs after the third following edge. `out_valid` repeats `pix_valid` three cycles later, and `out_sol` repeats (`pix_sol` AND `pix_valid`) three cycles later.
- R3: A valid pixel with `pix_sol`=1 uses column 0. Each other valid pixel uses the column after the previous valid pixel's column, wrapping modulo 2^AW. Cycles with `pix_valid`=0 do not advance the column.
- R4: The offset word (`cw_sel`=0) holds a 10-bit two's-complement value in bits [9:0], counted in half LSBs, so the offset is -256 to +255.5. Bits [15:10] have no effect.
- R5: The gain word (`cw_sel`=1) holds a 12-bit unsigned value g in bits [11:0], and the applied gain is 1 + g/1024. Bits [15:12] have no effect.
- R6: With `ffc_on`=1 the output is floor((in - offset) * gain + 0.5), saturated to 0 below and to 4095 above.
- R7: With `ffc_on`=0 (sampled with the pixel) the output equals the input pixel.
- R8: A pulse on `clr_ofs` makes every offset 0, and a pulse on `clr_gain` makes every gain x1. Each strobe leaves the other bank untouched, and both take effect for pixels accepted after the pulse edge.
- R9: A coefficient write in the same cycle as its bank's clear strobe is kept. Every other entry of that bank is cleared.
- R10: The write port is accepted on any cycle. If a write hits the column being read in the same cycle, that pixel uses the old value and the next pixel on that column uses the new one.
- R11: After reset every coefficient is neutral, so corrected output equals the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ffc_on | input | 1 | 1 applies the correction, 0 passes the pixel through |
| pix_valid | input | 1 | Input pixel valid |
| pix_sol | input | 1 | Start of line; valid only together with pix_valid |
| pix_data | input | PIX_W | Input pixel, unsigned |
| cw_en | input | 1 | Coefficient write strobe |
| cw_sel | input | 1 | Bank select: 0 offset, 1 gain |
| cw_addr | input | AW | Column written |
| cw_data | input | COEF_W | Coefficient word |
| clr_ofs | input | 1 | Clear all offsets to 0 |
| clr_gain | input | 1 | Clear all gains to x1 |
| out_valid | output | 1 | Output pixel valid |
| out_sol | output | 1 | Output start of line |
| out_data | output | PIX_W | Corrected pixel |

## Verification
The bound assertions check on every cycle the behaviour that depends only on the ports:
- the three-cycle delay of the valid and start-of-line flags;
- the bypass path that returns the input pixel;
- the quiet outputs during and just after reset.

The arithmetic can only be shown by the bench's scenarios, which compare against a model that keeps its own coefficient copies and column count. These include:
- rounding, and saturation at both ends;
- the ignored upper coefficient bits;
- column tracking across idle gaps and early start-of-line markers;
- clears on each bank, including a write in the same cycle as a clear;
- a write to the column being read, which must not take effect until the next line.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic {BANK_OFS = 1'b0, BANK_GAIN = 1'b1} ffc_bank_e;
  localparam int NBANKS = 2;
endpackage

// File: rtl/ffc_col_counter.sv
module ffc_col_counter #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          sol,
  output logic [AW-1:0] col
);
  logic [AW-1:0] next_q;

  always_comb col = (valid && sol) ? '0 : next_q;

  always_ff @(posedge clk) begin
    if (rst)        next_q <= '0;
    else if (valid) next_q <= col + AW'(1);
  end
endmodule

// File: rtl/ffc_coef_bank.sv
module ffc_coef_bank #(
  parameter int DEPTH = 1024,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] live;
  logic [W-1:0]     mem_q;
  logic             live_q;

  // Plain read-first array, free of reset, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // One flag per entry: clearing is a one-cycle flag wipe, and a
  // same-cycle write re-arms its own entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= live[raddr];
      if (clr) live <= '0;
      if (we)  live[waddr] <= 1'b1;
    end
  end

  always_comb rdata = live_q ? mem_q : '0;
endmodule

// File: rtl/ffc_correct.sv
module ffc_correct #(
  parameter int PIX_W     = 12,
  parameter int OFS_W     = 10,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_sol,
  input  logic              in_byp,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [GAIN_W-1:0] gain,
  output logic              out_vld,
  output logic              out_sol,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int DIFF_W  = PIX_W + 3;
  localparam int MUL_W   = GAIN_W + 2;
  localparam int PROD_W  = DIFF_W + MUL_W;
  localparam int SH      = GAIN_FRAC + 1;
  localparam int ONE     = 1 << GAIN_FRAC;
  localparam int HALF    = 1 << (SH - 1);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic signed [DIFF_W-1:0] diff_c, d2;
  logic        [MUL_W-1:0]  gm_c, gm2;
  logic        [PIX_W-1:0]  pix2;
  logic                     vld2, sol2, byp2;
  logic signed [PROD_W-1:0] prod_c, rnd_c;
  logic        [PIX_W-1:0]  sat_c;

  // Stage 2: subtract in half-LSB units and form 1 + g/2^FRAC.
  always_comb begin
    diff_c = $signed({2'b00, in_pix, 1'b0})
           - $signed({{(DIFF_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    gm_c   = MUL_W'(ONE) + MUL_W'(gain);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld2 <= 1'b0;
      sol2 <= 1'b0;
    end else begin
      vld2 <= in_vld;
      sol2 <= in_sol;
    end
    d2   <= diff_c;
    gm2  <= gm_c;
    pix2 <= in_pix;
    byp2 <= in_byp;
  end

  // Stage 3: multiply, round half up, saturate.
  always_comb begin
    prod_c = $signed({{(PROD_W-DIFF_W){d2[DIFF_W-1]}}, d2})
           * $signed({{(PROD_W-MUL_W){1'b0}}, gm2});
    rnd_c  = (prod_c + $signed(PROD_W'(HALF))) >>> SH;
    if (rnd_c < 0)                              sat_c = '0;
    else if (rnd_c > $signed(PROD_W'(PIX_MAX))) sat_c = PIX_W'(PIX_MAX);
    else                                        sat_c = rnd_c[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_sol <= 1'b0;
      out_pix <= '0;
    end else begin
      out_vld <= vld2;
      out_sol <= sol2;
      out_pix <= byp2 ? pix2 : sat_c;
    end
  end
endmodule

// File: rtl/ffc_pixel_pipe.sv
module ffc_pixel_pipe
  import ffc_pkg::*;
#(
  parameter int NCOLS     = 1024,
  parameter int PIX_W     = 12,
  parameter int COEF_W    = 16,
  parameter int OFS_W     = 10,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10,
  localparam int AW       = $clog2(NCOLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ffc_on,
  input  logic              pix_valid,
  input  logic              pix_sol,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              cw_en,
  input  logic              cw_sel,
  input  logic [AW-1:0]     cw_addr,
  input  logic [COEF_W-1:0] cw_data,
  input  logic              clr_ofs,
  input  logic              clr_gain,
  output logic              out_valid,
  output logic              out_sol,
  output logic [PIX_W-1:0]  out_data
);
  logic [AW-1:0]     col;
  logic [COEF_W-1:0] coef [NBANKS];
  logic              vld1, sol1, byp1;
  logic [PIX_W-1:0]  pix1;

  ffc_col_counter #(.AW(AW)) u_col (
    .clk(clk), .rst(rst), .valid(pix_valid), .sol(pix_sol), .col(col)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic bank_we, bank_clr;
    always_comb begin
      bank_we  = cw_en && (cw_sel == 1'(b));
      bank_clr = (1'(b) == BANK_GAIN) ? clr_gain : clr_ofs;
    end
    ffc_coef_bank #(.DEPTH(NCOLS), .W(COEF_W)) u_bank (
      .clk(clk), .rst(rst), .clr(bank_clr), .we(bank_we),
      .waddr(cw_addr), .wdata(cw_data), .raddr(col), .rdata(coef[b])
    );
  end

  // Stage 1: pixel waits alongside the coefficient read.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld1 <= 1'b0;
      sol1 <= 1'b0;
    end else begin
      vld1 <= pix_valid;
      sol1 <= pix_valid && pix_sol;
    end
    byp1 <= !ffc_on;
    pix1 <= pix_data;
  end

  ffc_correct #(
    .PIX_W(PIX_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_corr (
    .clk(clk), .rst(rst), .in_vld(vld1), .in_sol(sol1), .in_byp(byp1),
    .in_pix(pix1),
    .ofs(coef[BANK_OFS][OFS_W-1:0]),
    .gain(coef[BANK_GAIN][GAIN_W-1:0]),
    .out_vld(out_valid), .out_sol(out_sol), .out_pix(out_data)
  );
endmodule

// File: rtl/ffc_pipe_checker.sv
module ffc_pipe_checker #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ffc_on,
  input logic             pix_valid,
  input logic             pix_sol,
  input logic [PIX_W-1:0] pix_data,
  input logic             out_valid,
  input logic             out_sol,
  input logic [PIX_W-1:0] out_data
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sol && out_data == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(pix_valid, 3)));

  a_r2_sol_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_sol == $past(pix_valid && pix_sol, 3)));

  a_r7_bypass_passes: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(pix_valid && !ffc_on, 3))
      |-> (out_data == $past(pix_data, 3)));
endmodule

bind ffc_pixel_pipe ffc_pipe_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .ffc_on(ffc_on), .pix_valid(pix_valid),
  .pix_sol(pix_sol), .pix_data(pix_data), .out_valid(out_valid),
  .out_sol(out_sol), .out_data(out_data)
);

// File: tb/ffc_pixel_pipe_bench.sv
module ffc_pixel_pipe_bench;
  localparam int CLK_NS = 10;
  localparam int NC     = 32;
  localparam int AW     = $clog2(NC);

  logic clk = 1'b0, rst = 1'b1;
  logic ffc_on = 1'b1, pix_valid = 1'b0, pix_sol = 1'b0;
  logic [11:0] pix_data = '0;
  logic cw_en = 1'b0, cw_sel = 1'b0, clr_ofs = 1'b0, clr_gain = 1'b0;
  logic [AW-1:0] cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic out_valid, out_sol;
  logic [11:0] out_data;

  ffc_pixel_pipe #(.NCOLS(NC)) u_ffc_pixel_pipe (
    .clk(clk), .rst(rst), .ffc_on(ffc_on), .pix_valid(pix_valid),
    .pix_sol(pix_sol), .pix_data(pix_data), .cw_en(cw_en), .cw_sel(cw_sel),
    .cw_addr(cw_addr), .cw_data(cw_data), .clr_ofs(clr_ofs),
    .clr_gain(clr_gain), .out_valid(out_valid), .out_sol(out_sol),
    .out_data(out_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_ofs [NC];
  logic [15:0] m_gain [NC];
  int m_col = 0;
  // expectation history, index 2 is oldest
  bit    h_v [3];
  bit    h_s [3];
  int    h_d [3];
  string h_t [3];

  function automatic int ref_pix(int p, logic [15:0] ow, logic [15:0] gw);
    int o, dh, r;
    longint prod;
    o = int'($signed(ow[9:0]));
    dh = 2 * p - o;
    prod = longint'(dh) * longint'(1024 + int'(gw[11:0]));
    r = int'((prod + 1024) >>> 11);
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hist_clear();
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 0; h_s[i] = 0; h_d[i] = 0; h_t[i] = "R1";
    end
  endtask

  // One cycle: check due outputs, drive inputs, update the model.
  task automatic step(bit v, bit s, int p, bit on, bit we, bit sel,
                      int wa, int wd, bit co, bit cg, string tag);
    int c, e;
    chk({h_t[2], " R2 valid"}, int'(out_valid), int'(h_v[2]));
    chk({h_t[2], " R2 sol"}, int'(out_sol), int'(h_s[2]));
    if (h_v[2]) chk(h_t[2], int'(out_data), h_d[2]);
    pix_valid = v; pix_sol = s; pix_data = 12'(p); ffc_on = on;
    cw_en = we; cw_sel = sel; cw_addr = AW'(wa); cw_data = 16'(wd);
    clr_ofs = co; clr_gain = cg;
    c = (v && s) ? 0 : m_col;
    e = on ? ref_pix(p, m_ofs[c], m_gain[c]) : p;
    if (v) m_col = (c + 1) % NC;
    h_v[2] = h_v[1]; h_s[2] = h_s[1]; h_d[2] = h_d[1]; h_t[2] = h_t[1];
    h_v[1] = h_v[0]; h_s[1] = h_s[0]; h_d[1] = h_d[0]; h_t[1] = h_t[0];
    h_v[0] = v; h_s[0] = v && s; h_d[0] = e; h_t[0] = tag;
    if (co) for (int i = 0; i < NC; i++) m_ofs[i] = '0;
    if (cg) for (int i = 0; i < NC; i++) m_gain[i] = '0;
    if (we) begin
      if (sel) m_gain[wa] = 16'(wd);
      else     m_ofs[wa]  = 16'(wd);
    end
    @(negedge clk);
  endtask

  task automatic pix(bit s, int p, string tag);
    step(1, s, p, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(bit sel, int a, int d, string tag);
    step(0, 0, 0, 1, 1, sel, a, d, 0, 0, tag);
  endtask

  task automatic flush(string tag);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NC; i++) begin m_ofs[i] = '0; m_gain[i] = '0; end
    hist_clear();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 data in reset", int'(out_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sol after reset", int'(out_sol), 0);

    // R11: neutral after reset
    for (int i = 0; i < NC; i++) pix(i == 0, (i * 131) % 4096, "R11");
    flush("R11");

    // R6 corners: clamp high, clamp low, half rounding
    wr(0, 0, 16'h0200, "R6");  wr(1, 0, 16'h0FFF, "R6");
    wr(0, 1, 16'h01FF, "R6");
    wr(0, 2, 16'h0001, "R6");
    wr(0, 3, 16'h03FF, "R6");  wr(1, 3, 16'h0200, "R6");
    pix(1, 4095, "R6 clamp high"); pix(0, 0, "R6 clamp low");
    pix(0, 10, "R6 round half"); pix(0, 7, "R6 negative offset");
    flush("R6");

    // R4 / R5: upper bits have no effect
    wr(0, 4, 16'hFC10, "R4");  wr(1, 4, 16'hF100, "R5");
    wr(0, 5, 16'h7A00 | 16'h3F0, "R4"); wr(1, 5, 16'hA7FF, "R5");
    step(1, 1, 1000, 1, 0, 0, 0, 0, 0, 0, "R3 restart");
    for (int i = 1; i < 6; i++) pix(0, 1000 + i, i >= 4 ? "R4 R5" : "R3");
    flush("R4");

    // R7: bypass with active coefficients
    step(1, 1, 4095, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    flush("R7");

    // R10: write column 1 in the cycle it is read
    step(1, 1, 2000, 1, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 2000, 1, 1, 1, 1, 16'h0400, 0, 0, "R10 old value");
    step(1, 1, 2000, 1, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 2000, 1, 0, 0, 0, 0, 0, 0, "R10 new value");
    flush("R10");

    // Random lines with gaps, writes at any time, early restarts
    for (int ln = 0; ln < 40; ln++) begin
      for (int k = 0; k < NC; k++) begin
        bit v, w;
        v = ($urandom % 4) != 0;
        w = ($urandom % 3) == 0;
        step(v, k == 0 || ($urandom % 64) == 0, int'($urandom % 4096),
             ($urandom % 8) != 0, w, 1'($urandom), int'($urandom % NC),
             int'($urandom % 65536), 0, 0, "R3 R6 R10");
      end
    end
    flush("R6");

    // R8: clear offsets only, then gains only
    step(0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R8");
    for (int i = 0; i < NC; i++) pix(i == 0, 2048 + i, "R8 offsets cleared");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R8");
    for (int i = 0; i < NC; i++) pix(i == 0, 300 + i * 50, "R8 gains cleared");
    flush("R8");

    // R9: write kept when it lands with the clear
    for (int i = 0; i < NC; i++) wr(0, i, 16'h0155, "R9");
    step(0, 0, 0, 1, 1, 0, 6, 16'h0021, 1, 0, "R9");
    for (int i = 0; i < 8; i++) pix(i == 0, 1500, "R9 write survives clear");
    flush("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule